// File: doc/BRIEF.md
# Blocked-Multithreading Thread Switch Controller

This controller decides which hardware thread owns a blocked-multithreading pipeline. One thread keeps issuing for as long as it only meets short stalls. When that thread reports a costly stall, such as a miss in the second-level cache, the controller stops fetch and saves the thread's program counter. It then holds the pipeline in a drain/freeze condition until the pipeline reports that it is empty.

Once the pipeline is empty, the controller picks the next thread that is not waiting on a miss. It searches in round-robin order, starting at the thread just after the current one. It restores that thread's program counter and lets fetch run for a fixed refill window of `DEPTH` cycles before it accepts another switch request. A thread that missed stays marked as waiting until its miss-done line pulses. If every thread is waiting, fetch stays off until a miss resolves, and the thread whose miss resolved is resumed. Two counters record the number of accepted switches and the number of cycles spent outside normal running.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: After reset, `active_tid` is 0, `fetch_en` is 1, and `flush`, `pc_save`, `pc_restore`, `switch_cnt` and `lost_cnt` are all 0.
- R2: In the running state, a stall with `stall_evt`=1, `stall_long`=1 and `stall_tid` equal to `active_tid` drives `pc_save` high in that same cycle. In the following cycle `fetch_en` is 0 and `flush` is 1.
- R3: A stall request has no effect in any of these cases: `stall_long`=0, `stall_tid` differs from `active_tid`, or the controller is draining. No effect means `pc_save` stays 0 and `fetch_en` stays at its value.
- R4: While draining, `flush` is 1 and `fetch_en` is 0 until the first cycle in which `pipe_empty` is sampled high. The drain ends at the clock edge that samples it.
- R5: After the drain, the new thread is the first thread not marked waiting in the order `active_tid`+1, +2, and so on, wrapping modulo `NT`, with the current thread checked last. `pc_restore` is 1 in the selection cycle, and `active_tid` takes the new value at the next edge.
- R6: A thread that takes an accepted long stall is marked waiting. It is skipped by selection until its bit of `miss_done` has pulsed.
- R7: If every thread is waiting, `fetch_en`, `flush` and `pc_restore` all stay 0 until a miss resolves. The thread whose miss resolved is then selected, even if it is the thread that stalled.
- R8: After `pc_restore`, `fetch_en` is 1 for exactly `DEPTH` cycles of refill. A long stall during refill is ignored. The first running cycle after refill accepts a long stall again.
- R9: `switch_cnt` rises by one for each accepted long stall. `lost_cnt` rises by one for each cycle spent draining, selecting or refilling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_evt | input | 1 | A stall is being reported this cycle |
| stall_long | input | 1 | The reported stall is costly (e.g. second-level miss) |
| stall_tid | input | $clog2(NT) | Thread that reported the stall |
| miss_done | input | NT | Per-thread pulse: outstanding miss has resolved |
| pipe_empty | input | 1 | Pipeline holds no in-flight instructions |
| active_tid | output | $clog2(NT) | Thread currently owning the pipeline |
| fetch_en | output | 1 | Fetch may issue for `active_tid` |
| flush | output | 1 | Drain/freeze command to the pipeline |
| pc_save | output | 1 | Store the program counter of `active_tid` |
| pc_restore | output | 1 | Load the program counter of the thread being selected |
| switch_cnt | output | CW | Number of accepted switches |
| lost_cnt | output | CW | Cycles spent draining, selecting and refilling |

## Verification
The bench first drives short stalls, stalls tagged with another thread, and stalls raised during a drain or a refill. These show that only a costly stall from the running thread starts a switch. It then drives a slow drain with `pipe_empty` held low for several cycles, followed by a chain of switches in which waiting threads must be skipped, including a wrap-around past thread 0. This separates true round-robin order from a fixed-priority choice. Two cases where every thread is waiting show whether the controller resumes another thread or the same thread after the miss resolves. The loss counter is checked against the cycle totals worked out for the drain, the stuck selection and the refill.

// File: rtl/cgmt_pkg.sv
`timescale 1ns/1ps
package cgmt_pkg;
   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_DRAIN  = 2'd1,
      ST_SELECT = 2'd2,
      ST_REFILL = 2'd3
   } cgmt_state_e;
endpackage

// File: rtl/cgmt_wait_flags.sv
`timescale 1ns/1ps
module cgmt_wait_flags #(
   parameter int NT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NT-1:0] set_vec,
   input  logic [NT-1:0] clr_vec,
   output logic [NT-1:0] waiting
);
   for (genvar i = 0; i < NT; i++) begin : g_flag
      // a fresh miss beats a resolve arriving in the same cycle
      always_ff @(posedge clk) begin
         if (!rst_n)          waiting[i] <= 1'b0;
         else if (set_vec[i]) waiting[i] <= 1'b1;
         else if (clr_vec[i]) waiting[i] <= 1'b0;
      end

      a_r6_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[i] |=> waiting[i]);
      a_r6_clear_frees: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_vec[i] && !set_vec[i]) |=> !waiting[i]);
   end
endmodule

// File: rtl/cgmt_rr_pick.sv
`timescale 1ns/1ps
module cgmt_rr_pick #(
   parameter int NT = 4,
   localparam int TW = $clog2(NT)
) (
   input  logic [TW-1:0] cur,
   input  logic [NT-1:0] ready,
   output logic          valid,
   output logic [TW-1:0] pick
);
   int unsigned idx;

   // scan from the farthest slot to the nearest; the nearest ready wins
   always_comb begin
      valid = 1'b0;
      pick  = cur;
      idx   = 0;
      for (int k = NT; k >= 1; k--) begin
         idx = int'(cur) + k;
         if (idx >= NT) idx = idx - NT;
         if (ready[idx]) begin
            valid = 1'b1;
            pick  = idx[TW-1:0];
         end
      end
   end

   always_comb begin
      if (valid) a_r5_pick_ready: assert (ready[pick]);
      if (ready != '0) a_r5_valid_any: assert (valid);
   end
endmodule

// File: rtl/cgmt_loss_stats.sv
`timescale 1ns/1ps
module cgmt_loss_stats #(
   parameter int CW       = 16,
   parameter bit SATURATE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_inc,
   input  logic          loss_inc,
   output logic [CW-1:0] sw_cnt,
   output logic [CW-1:0] loss_cnt
);
   localparam logic [CW-1:0] CNT_MAX = '1;

   if (CW < 2) begin : g_bad_cw
      $error("cgmt_loss_stats: CW must be at least 2");
   end

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sw_cnt   <= '0;
            loss_cnt <= '0;
         end else begin
            if (sw_inc && sw_cnt != CNT_MAX)     sw_cnt   <= sw_cnt + 1'b1;
            if (loss_inc && loss_cnt != CNT_MAX) loss_cnt <= loss_cnt + 1'b1;
         end
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sw_cnt   <= '0;
            loss_cnt <= '0;
         end else begin
            if (sw_inc)   sw_cnt   <= sw_cnt + 1'b1;
            if (loss_inc) loss_cnt <= loss_cnt + 1'b1;
         end
      end

      a_r9_loss_moves: assert property (@(posedge clk) disable iff (!rst_n)
         loss_inc |=> (loss_cnt != $past(loss_cnt)));
      a_r9_loss_holds: assert property (@(posedge clk) disable iff (!rst_n)
         !loss_inc |=> $stable(loss_cnt));
      a_r9_sw_holds: assert property (@(posedge clk) disable iff (!rst_n)
         !sw_inc |=> $stable(sw_cnt));
   end
endmodule

// File: rtl/cgmt_switch_ctrl.sv
`timescale 1ns/1ps
module cgmt_switch_ctrl
   import cgmt_pkg::*;
#(
   parameter int NT       = 4,
   parameter int DEPTH    = 5,
   parameter int CW       = 16,
   parameter bit SAT_CNT  = 1'b0,
   localparam int TW      = $clog2(NT),
   localparam int RCW     = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stall_evt,
   input  logic          stall_long,
   input  logic [TW-1:0] stall_tid,
   input  logic [NT-1:0] miss_done,
   input  logic          pipe_empty,
   output logic [TW-1:0] active_tid,
   output logic          fetch_en,
   output logic          flush,
   output logic          pc_save,
   output logic          pc_restore,
   output logic [CW-1:0] switch_cnt,
   output logic [CW-1:0] lost_cnt
);
   if (NT < 2) begin : g_bad_nt
      $error("cgmt_switch_ctrl: NT must be at least 2");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("cgmt_switch_ctrl: DEPTH must be at least 1");
   end

   cgmt_state_e    state_q, state_d;
   logic [TW-1:0]  active_q;
   logic [RCW-1:0] refill_q;
   logic           trig;
   logic [NT-1:0]  set_vec;
   logic [NT-1:0]  waiting;
   logic           pick_valid;
   logic [TW-1:0]  pick_tid;
   logic           refill_last;

   assign trig = (state_q == ST_RUN) && stall_evt && stall_long
                 && (stall_tid == active_q);

   for (genvar i = 0; i < NT; i++) begin : g_set
      assign set_vec[i] = trig && (active_q == TW'(i));
   end

   cgmt_wait_flags #(.NT(NT)) i_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (miss_done),
      .waiting (waiting)
   );

   cgmt_rr_pick #(.NT(NT)) i_pick (
      .cur   (active_q),
      .ready (~waiting),
      .valid (pick_valid),
      .pick  (pick_tid)
   );

   assign refill_last = (refill_q == RCW'(DEPTH - 1));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:    if (trig)        state_d = ST_DRAIN;
         ST_DRAIN:  if (pipe_empty)  state_d = ST_SELECT;
         ST_SELECT: if (pick_valid)  state_d = ST_REFILL;
         ST_REFILL: if (refill_last) state_d = ST_RUN;
         default:                    state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_RUN;
         active_q <= '0;
         refill_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_SELECT && pick_valid) begin
            active_q <= pick_tid;
            refill_q <= '0;
         end else if (state_q == ST_REFILL && !refill_last) begin
            refill_q <= refill_q + 1'b1;
         end
      end
   end

   assign active_tid = active_q;
   assign fetch_en   = (state_q == ST_RUN) || (state_q == ST_REFILL);
   assign flush      = (state_q == ST_DRAIN);
   assign pc_save    = trig;
   assign pc_restore = (state_q == ST_SELECT) && pick_valid;

   cgmt_loss_stats #(.CW(CW), .SATURATE(SAT_CNT)) i_stats (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_inc   (trig),
      .loss_inc (state_q != ST_RUN),
      .sw_cnt   (switch_cnt),
      .loss_cnt (lost_cnt)
   );

   a_r2_save_then_flush: assert property (@(posedge clk) disable iff (!rst_n)
      pc_save |=> (flush && !fetch_en));
   a_r4_flush_blocks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !fetch_en);
   a_r4_drain_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && pipe_empty) |=> !flush);
   a_r5_tid_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_restore |=> $stable(active_tid));
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_en && !flush) |-> !pc_save);
   a_r8_restore_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      pc_restore |=> (fetch_en && !pc_save));
endmodule

// File: tb/test_cgmt_switch_ctrl.sv
`timescale 1ns/1ps
module test_cgmt_switch_ctrl;
   localparam int NT    = 4;
   localparam int DEPTH = 5;
   localparam int CW    = 16;
   localparam int TW    = $clog2(NT);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          stall_evt, stall_long;
   logic [TW-1:0] stall_tid;
   logic [NT-1:0] miss_done;
   logic          pipe_empty;
   logic [TW-1:0] active_tid;
   logic          fetch_en, flush, pc_save, pc_restore;
   logic [CW-1:0] switch_cnt, lost_cnt;

   int n_checks = 0;
   int n_fail   = 0;
   int cur_tid  = 0;
   int exp_sw   = 0;

   always #2.5 clk = ~clk;

   cgmt_switch_ctrl #(.NT(NT), .DEPTH(DEPTH), .CW(CW)) i_cgmt_switch_ctrl (
      .clk(clk), .rst_n(rst_n), .stall_evt(stall_evt), .stall_long(stall_long),
      .stall_tid(stall_tid), .miss_done(miss_done), .pipe_empty(pipe_empty),
      .active_tid(active_tid), .fetch_en(fetch_en), .flush(flush),
      .pc_save(pc_save), .pc_restore(pc_restore),
      .switch_cnt(switch_cnt), .lost_cnt(lost_cnt)
   );

   task automatic chk(input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; stall_evt = 0; stall_long = 0; stall_tid = '0;
      miss_done = '0; pipe_empty = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      chk("R1", "active_tid", active_tid, 0);
      chk("R1", "fetch_en", fetch_en, 1);
      chk("R1", "flush", flush, 0);
      chk("R1", "pc_save", pc_save, 0);
      chk("R1", "pc_restore", pc_restore, 0);
      chk("R1", "switch_cnt", switch_cnt, 0);
      chk("R1", "lost_cnt", lost_cnt, 0);
      tick();
   endtask

   task automatic t_ignored_stalls();
      stall_evt = 1; stall_long = 0; stall_tid = 0;
      #1 chk("R3", "short stall pc_save", pc_save, 0);
      tick();
      stall_long = 1; stall_tid = 2;
      #1 chk("R3", "foreign tid pc_save", pc_save, 0);
      tick();
      stall_evt = 0;
      #1;
      chk("R3", "fetch_en kept", fetch_en, 1);
      chk("R3", "no flush", flush, 0);
      chk("R3", "switch_cnt", switch_cnt, 0);
   endtask

   task automatic t_slow_drain();
      int lost0;
      lost0 = lost_cnt;
      pipe_empty = 0;
      stall_evt = 1; stall_long = 1; stall_tid = TW'(cur_tid);
      #1 chk("R2", "pc_save on long stall", pc_save, 1);
      tick();
      exp_sw++;
      stall_evt = 0;
      #1;
      chk("R2", "fetch_en off", fetch_en, 0);
      chk("R2", "flush on", flush, 1);
      chk("R9", "switch_cnt", switch_cnt, exp_sw);
      tick();
      stall_evt = 1; stall_long = 1; stall_tid = TW'(cur_tid);
      #1;
      chk("R3", "stall in drain pc_save", pc_save, 0);
      chk("R4", "flush held", flush, 1);
      tick();
      stall_evt = 0;
      #1;
      chk("R4", "flush held 3", flush, 1);
      chk("R4", "fetch_en off 3", fetch_en, 0);
      tick();
      pipe_empty = 1;
      tick();
      chk("R4", "drain ended", flush, 0);
      chk("R5", "pc_restore", pc_restore, 1);
      tick();
      cur_tid = 1;
      chk("R5", "active_tid", active_tid, 1);
      chk("R8", "refill fetch_en", fetch_en, 1);
      stall_evt = 1; stall_long = 1; stall_tid = 1;
      #1 chk("R8", "stall in refill pc_save", pc_save, 0);
      tick();
      stall_evt = 0;
      repeat (DEPTH - 1) tick();
      chk("R9", "lost cycles slow drain", lost_cnt - lost0, 10);
      chk("R9", "switch_cnt after refill", switch_cnt, exp_sw);
      chk("R8", "run fetch_en", fetch_en, 1);
   endtask

   task automatic do_switch(input int exp_next);
      int lost0;
      lost0 = lost_cnt;
      pipe_empty = 1;
      stall_evt = 1; stall_long = 1; stall_tid = TW'(cur_tid);
      #1 chk("R8", "long stall accepted", pc_save, 1);
      tick();
      exp_sw++;
      stall_evt = 0;
      #1 chk("R2", "flush", flush, 1);
      tick();
      chk("R5", "pc_restore", pc_restore, 1);
      tick();
      chk("R6", "next thread", active_tid, exp_next);
      cur_tid = exp_next;
      for (int c = 0; c < DEPTH; c++) begin
         if (c == DEPTH - 1) chk("R8", "still refilling", fetch_en, 1);
         tick();
      end
      chk("R9", "lost per fast switch", lost_cnt - lost0, DEPTH + 2);
      chk("R9", "switch_cnt", switch_cnt, exp_sw);
   endtask

   task automatic do_stuck(input int res_tid, input int s_cycles);
      int lost0;
      lost0 = lost_cnt;
      pipe_empty = 1;
      stall_evt = 1; stall_long = 1; stall_tid = TW'(cur_tid);
      #1 chk("R2", "pc_save", pc_save, 1);
      tick();
      exp_sw++;
      stall_evt = 0;
      tick();
      for (int s = 0; s < s_cycles; s++) begin
         chk("R7", "no restore while all wait", pc_restore, 0);
         chk("R7", "fetch_en off while all wait", fetch_en, 0);
         chk("R7", "no flush while all wait", flush, 0);
         if (s == s_cycles - 1) miss_done = NT'(1) << res_tid;
         tick();
      end
      miss_done = '0;
      #1 chk("R7", "restore after resolve", pc_restore, 1);
      tick();
      chk("R7", "resumed thread", active_tid, res_tid);
      cur_tid = res_tid;
      repeat (DEPTH) tick();
      chk("R9", "lost with stuck select", lost_cnt - lost0, s_cycles + DEPTH + 2);
   endtask

   initial begin
      t_reset();
      t_ignored_stalls();
      t_slow_drain();          // 0 -> 1, waiting {0}
      do_switch(2);            // R5: 1 -> 2
      do_switch(3);            // R5: 2 -> 3, waiting {0,1,2}
      do_stuck(1, 3);          // R6/R7: all wait, 1 resolves, 0 skipped
      miss_done = 4'b1000;     // R6: free thread 3
      tick();
      miss_done = '0;
      do_switch(3);            // R6: 1 -> 3, thread 2 still waiting is skipped
      do_stuck(3, 2);          // R7: the stalled thread itself resumes
      chk("R9", "total switches", switch_cnt, exp_sw);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule